// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an up-counter with two compare channels, A and B, that drive one waveform pin each. A three-bit mode field picks how the count moves and where its upper limit (TOP) comes from. The modes are a free-running count, a count that restarts after it matches compare A, a single-slope (fast) PWM, and a dual-slope (phase-correct) PWM that counts up and then down. The counter moves only on cycles where the `tick` input is high, so an external prescaler sets the rate.

Compare values are written through their own write ports. In the two non-PWM modes a written value is used at once. In the PWM modes the value is staged and takes effect when the count reaches TOP, so a period is never cut short. Three sticky flags report overflow and the two compare matches, and each flag is cleared by writing a one to its clear bit.

The control word holds the two compare-output fields and the mode. Two bits of that word are unused and always read back as zero.

Top module: `pwm_timer8`

## Requirements
- R1: Control layout `ctrl_wdata`/`ctrl_rd`: bits [8:7] output mode A, [6:5] output mode B, [4:3] unused, [2:0] waveform mode. TOP is 0xFF in modes 0 (free-running), 1 (phase-correct) and 3 (fast PWM). TOP is the active compare A value in modes 2 (restart on match), 5 (phase-correct) and 7 (fast PWM).
- R2: Reset clears the count, the direction, the three flags, both pins, the modes and the compare values. After reset the count changes only on a cycle with `tick` high, and it shows the new value after that clock edge.
- R3: Mode 0 counts up and wraps from 0xFF to 0x00. Modes 2, 3 and 7 count up and go to 0x00 on the tick taken while the count equals TOP.
- R4: Modes 1 and 5 count up from 0x00 to TOP and then down to 0x00, turning at each end without holding or repeating the end value.
- R5: In modes 0 and 2 a compare write takes effect on the next cycle. In modes 1, 3, 5 and 7 the written value is held in a staging register and copied to the active value on a tick taken at TOP.
- R6: On a tick, the overflow flag sets if the count is 0xFF in modes 0 to 3. In mode 5 it sets if the count is 0x00 while counting down. In mode 7 it sets if the count equals TOP.
- R7: On a tick, a channel's match flag sets if the count equals that channel's active compare value. `flag_clr` bit 0 clears overflow, bit 1 clears match A and bit 2 clears match B. A set in the same cycle wins over a clear.
- R8: Phase-correct output field: 10 clears the pin on an up-count match and sets it on a down-count match, 11 does the reverse, and 01 takes no action. Field 00 drives the pin output low in every mode.
- R9: In phase-correct mode, when the compare value equals TOP and the field's high bit is set, the match action is skipped. The pin is instead set (field 10) or cleared (field 11) on the tick at TOP.
- R10: Fast PWM: field 10 sets the pin on the tick at TOP and otherwise clears it on a match, and 11 does the reverse. Modes 0 and 2: on a match, 01 toggles the pin, 10 clears it and 11 sets it.
- R11: Modes 4 and 6 are reserved. They hold the count, the pins, the flags and the active compare values.
- R12: `ctrl_rd` bits [4:3] read as zero whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Count enable |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 9 | Control word write data |
| cmpa_we | input | 1 | Compare A write strobe |
| cmpa_wdata | input | 8 | Compare A write data |
| cmpb_we | input | 1 | Compare B write strobe |
| cmpb_wdata | input | 8 | Compare B write data |
| flag_clr | input | 3 | Write-one-to-clear: {match B, match A, overflow} |
| ctrl_rd | output | 9 | Control word readback |
| count | output | 8 | Current count |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| ovf_flag | output | 1 | Overflow flag |
| cmpa_flag | output | 1 | Compare A match flag |
| cmpb_flag | output | 1 | Compare B match flag |

## Verification
Every result here passes through exactly one register. The count, pins, flags, active compare values and control readback all show the effect of a cycle's inputs right after the next rising edge. A staged compare value becomes visible only in the cycle after the tick at TOP, so it first shows in the match and pin behaviour of the following period. The driver applies inputs on the falling edge and pushes the expected port values for the next rising edge into a queue. The monitor pops and compares them one time unit after that edge, so every comparison lines up with the single register stage.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [2:0] {
    WG_NORMAL   = 3'd0,
    WG_PC_MAX   = 3'd1,
    WG_CTC      = 3'd2,
    WG_FAST_MAX = 3'd3,
    WG_RSV4     = 3'd4,
    WG_PC_A     = 3'd5,
    WG_RSV6     = 3'd6,
    WG_FAST_A   = 3'd7
  } wg_mode_e;

  function automatic logic wg_reserved(input wg_mode_e m);
    return (m == WG_RSV4) || (m == WG_RSV6);
  endfunction

  function automatic logic wg_phase(input wg_mode_e m);
    return (m == WG_PC_MAX) || (m == WG_PC_A);
  endfunction

  function automatic logic wg_fast(input wg_mode_e m);
    return (m == WG_FAST_MAX) || (m == WG_FAST_A);
  endfunction

  function automatic logic wg_top_a(input wg_mode_e m);
    return (m == WG_CTC) || (m == WG_PC_A) || (m == WG_FAST_A);
  endfunction

  function automatic logic wg_immediate(input wg_mode_e m);
    return (m == WG_NORMAL) || (m == WG_CTC);
  endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wg_mode_e     mode,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         at_top,
  output logic         ovf_set
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;
  logic         adv;
  logic         ovf_raw;

  assign adv    = tick && !wg_reserved(mode);
  assign at_top = (cnt_q == top);

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (wg_phase(mode)) begin
      if (!dn_q) begin
        if (cnt_q >= top) begin
          dn_d  = 1'b1;
          cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == ZERO) begin
        dn_d  = 1'b0;
        cnt_d = (top == ZERO) ? ZERO : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end else if (mode == WG_NORMAL) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = at_top ? ZERO : cnt_q + ONE;
    end
  end

  always_comb begin
    unique case (mode)
      WG_NORMAL, WG_PC_MAX, WG_CTC, WG_FAST_MAX: ovf_raw = (cnt_q == MAXV);
      WG_PC_A:   ovf_raw = (cnt_q == ZERO) && dn_q;
      WG_FAST_A: ovf_raw = at_top;
      default:   ovf_raw = 1'b0;
    endcase
  end

  assign ovf_set = adv && ovf_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = dn_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R11
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wg_reserved(mode) |=> $stable(cnt_q));

  // R3
  fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wg_fast(mode) && cnt_q == top) |=> (cnt_q == ZERO));

  // R4
  pc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wg_phase(mode) && !dn_q && cnt_q < top) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/pwmt_cmpbuf.sv
module pwmt_cmpbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         immediate,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] stage_q, act_q, act_d;
  logic         act_en;

  always_comb begin
    act_en = 1'b0;
    act_d  = act_q;
    if (we && immediate) begin
      act_en = 1'b1;
      act_d  = wdata;
    end else if (load) begin
      act_en = 1'b1;
      act_d  = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (we) begin
      stage_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign act = act_q;

  // R5
  stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(we && immediate)) |=> (act_q == $past(stage_q)));

  // R5
  act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !we) |=> $stable(act_q));
endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wg_mode_e     mode,
  input  logic [1:0]   com,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic [W-1:0] cmp,
  input  logic         dir_down,
  output logic         wave
);
  logic pin_q, pin_d;
  logic match, at_top;

  assign match  = (cnt == cmp);
  assign at_top = (cnt == top);

  always_comb begin
    pin_d = pin_q;
    if (wg_reserved(mode)) begin
      pin_d = pin_q;
    end else if (wg_phase(mode)) begin
      if (com[1]) begin
        if (cmp == top) begin
          if (at_top) pin_d = ~com[0];
        end else if (match) begin
          pin_d = dir_down ? ~com[0] : com[0];
        end
      end
    end else if (wg_fast(mode)) begin
      if (com[1]) begin
        if (at_top)     pin_d = ~com[0];
        else if (match) pin_d = com[0];
      end
    end else if (match) begin
      unique case (com)
        2'b01:   pin_d = ~pin_q;
        2'b10:   pin_d = 1'b0;
        2'b11:   pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (tick) begin
      pin_q <= pin_d;
    end
  end

  assign wave = (com == 2'b00) ? 1'b0 : pin_q;

  // R11
  rsv_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wg_reserved(mode) |=> $stable(pin_q));

  // R9
  pc_top_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wg_phase(mode) && com == 2'b10 && cmp == top && at_top) |=> pin_q);
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwmt_pkg::*;
#(
  parameter int W  = 8,
  parameter int NC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ctrl_we,
  input  logic [8:0]   ctrl_wdata,
  input  logic         cmpa_we,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cmpb_we,
  input  logic [W-1:0] cmpb_wdata,
  input  logic [2:0]   flag_clr,
  output logic [8:0]   ctrl_rd,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         cmpa_flag,
  output logic         cmpb_flag
);
  localparam logic [W-1:0] MAXV = '1;

  logic [1:0]   rs_q;
  logic         rst_ns;
  wg_mode_e     mode_q;
  logic [1:0]   com_q  [NC];
  logic [W-1:0] cmp_wd [NC];
  logic         cmp_we [NC];
  logic [W-1:0] act    [NC];
  logic         wave   [NC];
  logic [NC:0]  flag_q, flag_set;
  logic [W-1:0] top;
  logic         dir_down, at_top, ovf_set, load, adv;
  logic         unused_rsv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  assign unused_rsv = ^ctrl_wdata[4:3];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q   <= WG_NORMAL;
      com_q[0] <= 2'b00;
      com_q[1] <= 2'b00;
    end else if (ctrl_we) begin
      mode_q   <= wg_mode_e'(ctrl_wdata[2:0]);
      com_q[0] <= ctrl_wdata[8:7];
      com_q[1] <= ctrl_wdata[6:5];
    end
  end

  assign ctrl_rd = {com_q[0], com_q[1], 2'b00, mode_q};

  assign top  = wg_top_a(mode_q) ? act[0] : MAXV;
  assign adv  = tick && !wg_reserved(mode_q);
  assign load = adv && at_top && !wg_immediate(mode_q);

  pwmt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .tick(tick), .mode(mode_q), .top(top),
    .cnt(count), .dir_down(dir_down), .at_top(at_top), .ovf_set(ovf_set)
  );

  assign cmp_we[0] = cmpa_we;
  assign cmp_wd[0] = cmpa_wdata;
  assign cmp_we[1] = cmpb_we;
  assign cmp_wd[1] = cmpb_wdata;

  assign flag_set[0] = ovf_set;

  for (genvar i = 0; i < NC; i++) begin : g_ch
    pwmt_cmpbuf #(.W(W)) u_buf (
      .clk(clk), .rst_n(rst_ns), .we(cmp_we[i]), .wdata(cmp_wd[i]),
      .immediate(wg_immediate(mode_q)), .load(load), .act(act[i])
    );
    pwmt_wave #(.W(W)) u_wave (
      .clk(clk), .rst_n(rst_ns), .tick(tick), .mode(mode_q), .com(com_q[i]),
      .cnt(count), .top(top), .cmp(act[i]), .dir_down(dir_down), .wave(wave[i])
    );
    assign flag_set[i+1] = adv && (count == act[i]);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign ovf_flag  = flag_q[0];
  assign cmpa_flag = flag_q[1];
  assign cmpb_flag = flag_q[2];
  assign wave_a    = wave[0];
  assign wave_b    = wave[1];

  // R7
  match_a_set_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick && !wg_reserved(mode_q) && count == act[0]) |=> cmpa_flag);

  // R7
  clr_b_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (flag_clr[2] && !(tick && !wg_reserved(mode_q) && count == act[1])) |=> !cmpb_flag);

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!tick && !flag_clr[0]) |=> $stable(ovf_flag));

  // R12
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_we |=> (ctrl_rd[4:3] == 2'b00));
endmodule

// File: tb/sim_pwm_timer8.sv
module sim_pwm_timer8;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, ctrl_we, cmpa_we, cmpb_we;
  logic [8:0] ctrl_wdata, ctrl_rd;
  logic [7:0] cmpa_wdata, cmpb_wdata, count;
  logic [2:0] flag_clr;
  logic       wave_a, wave_b, ovf_flag, cmpa_flag, cmpb_flag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
    .flag_clr(flag_clr), .ctrl_rd(ctrl_rd), .count(count), .wave_a(wave_a), .wave_b(wave_b),
    .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
  );

  typedef struct packed {
    logic [7:0] cnt;
    logic       wa, wb, ovf, fa, fb;
    logic [8:0] crd;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  // reference state
  logic [7:0] m_cnt, m_bufa, m_acta, m_bufb, m_actb;
  logic       m_dir, m_ovf, m_fa, m_fb, m_pa, m_pb;
  logic [2:0] m_mode;
  logic [1:0] m_coma, m_comb;

  task automatic chk(input string what, input string tag, input logic [8:0] a, input logic [8:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, a, e);
    end
  endtask

  function automatic logic pin_nx(input logic pin, input logic [2:0] md, input logic [1:0] com,
                                  input logic [7:0] cmp, input logic [7:0] c, input logic [7:0] tp,
                                  input logic dn);
    if (md == 3'd4 || md == 3'd6) return pin;
    if (md == 3'd1 || md == 3'd5) begin
      if (!com[1]) return pin;
      if (cmp == tp) return (c == tp) ? ~com[0] : pin;
      if (c == cmp) return dn ? ~com[0] : com[0];
      return pin;
    end
    if (md == 3'd3 || md == 3'd7) begin
      if (!com[1]) return pin;
      if (c == tp) return ~com[0];
      if (c == cmp) return com[0];
      return pin;
    end
    if (c == cmp) begin
      if (com == 2'b01) return ~pin;
      if (com == 2'b10) return 1'b0;
      if (com == 2'b11) return 1'b1;
    end
    return pin;
  endfunction

  task automatic model_step(input logic tk, input logic cwe, input logic [8:0] cw,
                            input logic awe, input logic [7:0] aw, input logic bwe,
                            input logic [7:0] bw, input logic [2:0] clr);
    logic rsv, pc, imm, atop, ovs, sa, sb, ld;
    logic [7:0] tp, nc;
    logic nd;
    rsv  = (m_mode == 3'd4) || (m_mode == 3'd6);
    pc   = (m_mode == 3'd1) || (m_mode == 3'd5);
    imm  = (m_mode == 3'd0) || (m_mode == 3'd2);
    tp   = (m_mode == 3'd2 || m_mode == 3'd5 || m_mode == 3'd7) ? m_acta : 8'hFF;
    atop = (m_cnt == tp);
    nc = m_cnt; nd = m_dir; ovs = 1'b0;
    if (tk && !rsv) begin
      if (pc) begin
        if (!m_dir) begin
          if (m_cnt >= tp) begin nd = 1'b1; nc = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1; end
          else nc = m_cnt + 8'd1;
        end else if (m_cnt == 0) begin nd = 1'b0; nc = (tp == 0) ? 8'd0 : 8'd1; end
        else nc = m_cnt - 8'd1;
      end else if (m_mode == 3'd0) nc = m_cnt + 8'd1;
      else nc = atop ? 8'd0 : m_cnt + 8'd1;
      if (m_mode <= 3'd3) ovs = (m_cnt == 8'hFF);
      else if (m_mode == 3'd5) ovs = (m_cnt == 0) && m_dir;
      else if (m_mode == 3'd7) ovs = atop;
    end
    sa = tk && !rsv && (m_cnt == m_acta);
    sb = tk && !rsv && (m_cnt == m_actb);
    ld = tk && !rsv && atop && !imm;
    if (tk) begin
      m_pa = pin_nx(m_pa, m_mode, m_coma, m_acta, m_cnt, tp, m_dir);
      m_pb = pin_nx(m_pb, m_mode, m_comb, m_actb, m_cnt, tp, m_dir);
    end
    m_ovf = (m_ovf & ~clr[0]) | ovs;
    m_fa  = (m_fa & ~clr[1]) | sa;
    m_fb  = (m_fb & ~clr[2]) | sb;
    if (awe && imm) m_acta = aw; else if (ld) m_acta = m_bufa;
    if (bwe && imm) m_actb = bw; else if (ld) m_actb = m_bufb;
    if (awe) m_bufa = aw;
    if (bwe) m_bufb = bw;
    m_cnt = nc; m_dir = nd;
    if (cwe) begin m_mode = cw[2:0]; m_coma = cw[8:7]; m_comb = cw[6:5]; end
  endtask

  task automatic cyc(input logic tk, input logic cwe, input logic [8:0] cw,
                     input logic awe, input logic [7:0] aw, input logic bwe,
                     input logic [7:0] bw, input logic [2:0] clr, input string tag);
    exp_t e;
    @(negedge clk);
    tick = tk; ctrl_we = cwe; ctrl_wdata = cw; cmpa_we = awe; cmpa_wdata = aw;
    cmpb_we = bwe; cmpb_wdata = bw; flag_clr = clr;
    model_step(tk, cwe, cw, awe, aw, bwe, bw, clr);
    e.cnt = m_cnt;
    e.wa  = (m_coma == 2'b00) ? 1'b0 : m_pa;
    e.wb  = (m_comb == 2'b00) ? 1'b0 : m_pb;
    e.ovf = m_ovf; e.fa = m_fa; e.fb = m_fb;
    e.crd = {m_coma, m_comb, 2'b00, m_mode};
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic run(input int n, input int gap, input int clr_every, input string tag);
    for (int i = 1; i <= n; i++) begin
      cyc((gap == 0) || (i % gap != 0), 1'b0, 9'd0, 1'b0, 8'd0, 1'b0, 8'd0,
          (clr_every != 0 && i % clr_every == 0) ? 3'b111 : 3'b000, tag);
    end
  endtask

  task automatic setc(input logic [1:0] ca, input logic [1:0] cb, input logic [2:0] md, input string tag);
    cyc(1'b0, 1'b1, {ca, cb, 2'b00, md}, 1'b0, 8'd0, 1'b0, 8'd0, 3'b000, tag);
  endtask

  task automatic setab(input logic [7:0] a, input logic [7:0] b, input string tag);
    cyc(1'b0, 1'b0, 9'd0, 1'b1, a, 1'b1, b, 3'b000, tag);
  endtask

  always @(posedge clk) begin : monitor
    exp_t  e;
    string t;
    #1;
    if (expq.size() != 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      chk("count", t, {1'b0, count}, {1'b0, e.cnt});
      chk("wave_a", t, {8'd0, wave_a}, {8'd0, e.wa});
      chk("wave_b", t, {8'd0, wave_b}, {8'd0, e.wb});
      chk("ovf_flag", t, {8'd0, ovf_flag}, {8'd0, e.ovf});
      chk("cmpa_flag", t, {8'd0, cmpa_flag}, {8'd0, e.fa});
      chk("cmpb_flag", t, {8'd0, cmpb_flag}, {8'd0, e.fb});
      chk("ctrl_rd", t, ctrl_rd, e.crd);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0;
    tick = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; cmpa_we = 1'b0; cmpa_wdata = '0;
    cmpb_we = 1'b0; cmpb_wdata = '0; flag_clr = '0;
    m_cnt = '0; m_bufa = '0; m_acta = '0; m_bufb = '0; m_actb = '0; m_dir = 1'b0;
    m_ovf = 1'b0; m_fa = 1'b0; m_fb = 1'b0; m_pa = 1'b0; m_pb = 1'b0;
    m_mode = '0; m_coma = '0; m_comb = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("reset count", "R2", {1'b0, count}, 9'd0);
    chk("reset flags", "R2", {6'd0, ovf_flag, cmpa_flag, cmpb_flag}, 9'd0);
    chk("reset pins", "R2", {7'd0, wave_a, wave_b}, 9'd0);
    chk("reset ctrl", "R2", ctrl_rd, 9'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: unused bits written as ones read back as zero
    cyc(1'b0, 1'b1, {2'b01, 2'b10, 2'b11, 3'd0}, 1'b1, 8'h10, 1'b1, 8'h80, 3'b000, "R12 R5");
    run(600, 3, 97, "R1 R2 R3 R6 R7 R10");

    setc(2'b01, 2'b11, 3'd2, "R1 R12");
    setab(8'h20, 8'h05, "R5");
    run(150, 0, 0, "R1 R3 R5 R7 R10");
    cyc(1'b1, 1'b0, 9'd0, 1'b1, 8'h08, 1'b0, 8'd0, 3'b000, "R5");
    run(300, 0, 40, "R1 R3 R5 R7 R10");

    setc(2'b10, 2'b11, 3'd3, "R1");
    setab(8'h40, 8'hFF, "R5");
    run(600, 0, 0, "R1 R3 R6 R10");

    setc(2'b10, 2'b11, 3'd7, "R1");
    setab(8'h30, 8'h10, "R5");
    run(200, 0, 0, "R1 R3 R5 R6 R10");
    setab(8'h50, 8'h20, "R5");
    run(300, 5, 0, "R1 R3 R5 R6 R10");

    setc(2'b10, 2'b11, 3'd1, "R1");
    setab(8'h40, 8'hFF, "R5");
    run(1200, 0, 50, "R4 R6 R8 R9");

    setc(2'b10, 2'b11, 3'd5, "R1");
    setab(8'h20, 8'h08, "R5");
    run(300, 0, 60, "R4 R6 R8 R9");
    setc(2'b10, 2'b01, 3'd5, "R8");
    run(100, 0, 0, "R8 R9");

    setc(2'b10, 2'b11, 3'd4, "R11");
    run(30, 0, 0, "R11");
    setc(2'b11, 2'b10, 3'd6, "R11");
    run(30, 0, 0, "R11");
    setc(2'b00, 2'b11, 3'd5, "R8");
    run(60, 0, 0, "R8");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule